// File: doc/BRIEF.md
# Restart Interrupt Mask and Priority Controller

This block owns the mask register and the pending logic for three fixed-priority restart interrupt levels, called 7.5, 6.5 and 5.5. Software writes one control byte to set the masks and to clear the 7.5 edge latch. It reads one status byte that shows the pending inputs, the interrupt-enable flag and the current masks. The block synchronizes the three interrupt pins to its clock. Level 7.5 is caught by a rising-edge latch. Levels 6.5 and 5.5 are sampled as levels.

The core drives the interrupt-enable flag with set and clear strobes. The block raises a single request whenever the flag is set and an unmasked level is pending. Along with the request it gives the winning level code and that level's restart vector. The core answers the request with an acknowledge pulse.

Top module: `rst_mask_ctrl`

## Requirements
- R1: After reset all three mask bits are 1, the 7.5 latch is clear, interrupt-enable is 0 and `irq_o` is 0. A status read with all pins low returns 0x07.
- R2: A write with bit 3 = 1 loads bits 2, 1 and 0 into the masks for 7.5, 6.5 and 5.5. A write with bit 3 = 0 leaves all masks unchanged.
- R3: A write with bit 4 = 1 clears the 7.5 latch, whatever the value of bit 3.
- R4: A rising edge on pin 7.5 sets its latch. The level stays pending after the pin returns low, until the latch is cleared.
- R5: Pending 6.5 and 5.5 follow the synchronized pin state. They are shown in the status byte even when the level is masked.
- R6: A level whose mask bit is 1 never produces a request.
- R7: Priority is fixed as 7.5 over 6.5 over 5.5. `irq_level_o` is 2, 1 or 0 and `vector_o` is 0x3C, 0x34 or 0x2C for 7.5, 6.5 and 5.5. When there is no request, both are 0.
- R8: `irq_o` is 1 only while interrupt-enable is 1 and at least one unmasked level is pending.
- R9: An acknowledge clears interrupt-enable. If the winning level was 7.5, the acknowledge also clears its latch.
- R10: A pulse on `rd_i` captures the status byte into `rd_data_o`, which is valid from the next cycle and held until the next read. The byte holds: bit 7 = 0; bits 6, 5, 4 = pending 7.5, 6.5, 5.5; bit 3 = interrupt-enable; bits 2, 1, 0 = masks for 7.5, 6.5, 5.5.
- R11: Write bits 7 to 5 have no effect.
- R12: `ie_set_i` sets interrupt-enable and `ie_clr_i` clears it. An acknowledge takes precedence over both, and set takes precedence over clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 3 | Interrupt pins: bit 2 = 7.5, bit 1 = 6.5, bit 0 = 5.5 |
| wr_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte |
| rd_i | input | 1 | Status read strobe |
| rd_data_o | output | 8 | Captured status byte |
| ie_set_i | input | 1 | Set interrupt-enable |
| ie_clr_i | input | 1 | Clear interrupt-enable |
| ack_i | input | 1 | Acknowledge of the current request |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 2 | Winning level code |
| vector_o | output | 8 | Restart vector of the winning level |

## Verification
The hardest state to reach from the ports is a 7.5 latch that is pending while the pin is already low and the level is masked, with lower levels also pending. Only in that state is it visible that the latch outlives the pin, and that a clear-only write or an acknowledge removes just the 7.5 level. The stimulus pulses the 7.5 pin for two cycles and lets it fall. It then raises 6.5 and 5.5, unmasks the levels, and clears the latch two different ways: with a clear-only write that leaves the masks alone, and with an acknowledge of a 7.5 request. After each step it reads the status byte and checks the level and vector that follow.

// File: rtl/rst_mask_pkg.sv
package rst_mask_pkg;
  localparam int unsigned NUM_LVL    = 3;
  localparam int unsigned LVL_W      = $clog2(NUM_LVL);
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WR_CLR_BIT = 4;  // clears 7.5 latch
  localparam int unsigned WR_MSE_BIT = 3;  // mask load enable
  localparam int unsigned EDGE_LVL   = NUM_LVL - 1;  // index of 7.5
  localparam logic [BYTE_W-1:0] VEC_BASE = 8'h2C;

  typedef logic [NUM_LVL-1:0] lvl_vec_t;

  // vector spacing of 8 bytes per level
  function automatic logic [BYTE_W-1:0] vector_of(input logic [LVL_W-1:0] lvl);
    logic [BYTE_W-1:0] off;
    off = BYTE_W'(lvl) << 3;
    return VEC_BASE + off;
  endfunction
endpackage

// File: rtl/rst_mask_sync.sv
module rst_mask_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) stage_q[s] <= d_i;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rst_mask_edge.sv
module rst_mask_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, rise;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // a fresh edge beats a clear in the same cycle
      if (rise)       pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rst_mask_prio.sv
module rst_mask_prio
  import rst_mask_pkg::*;
#(
  parameter int unsigned N   = NUM_LVL,
  parameter int unsigned IDX = $clog2(N)
) (
  input  logic [N-1:0]   req_i,
  output logic           valid_o,
  output logic [IDX-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = IDX'(i);  // highest index wins
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/rst_mask_ctrl.sv
module rst_mask_ctrl
  import rst_mask_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_LVL-1:0] irq_pin_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o,
  output logic [BYTE_W-1:0] vector_o
);
  lvl_vec_t          pin_sync, mask_q, pend, req;
  logic              ie_q, edge_pend, edge_clr, win_valid, unused_hi;
  logic [LVL_W-1:0]  win_idx;
  logic [BYTE_W-1:0] rd_q;

  assign unused_hi = ^wr_data_i[BYTE_W-1:WR_CLR_BIT+1];

  rst_mask_sync #(.WIDTH(NUM_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_pin_i),
    .q_o   (pin_sync)
  );

  assign edge_clr = (wr_i & wr_data_i[WR_CLR_BIT])
                  | (ack_i & irq_o & (irq_level_o == LVL_W'(EDGE_LVL)));

  rst_mask_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_sync[EDGE_LVL]),
    .clr_i (edge_clr),
    .pend_o(edge_pend)
  );

  // top level is edge latched, the rest follow the pins
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_pend
    if (l == EDGE_LVL) begin : g_edge
      assign pend[l] = edge_pend;
    end else begin : g_level
      assign pend[l] = pin_sync[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         mask_q <= '1;
    else if (wr_i && wr_data_i[WR_MSE_BIT]) mask_q <= wr_data_i[NUM_LVL-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ie_q <= 1'b0;
    else if (ack_i)    ie_q <= 1'b0;
    else if (ie_set_i) ie_q <= 1'b1;
    else if (ie_clr_i) ie_q <= 1'b0;
  end

  assign req = ie_q ? (pend & ~mask_q) : '0;

  rst_mask_prio #(.N(NUM_LVL), .IDX(LVL_W)) u_prio (
    .req_i  (req),
    .valid_o(win_valid),
    .idx_o  (win_idx)
  );

  assign irq_o       = win_valid;
  assign irq_level_o = win_valid ? win_idx : '0;
  assign vector_o    = win_valid ? vector_of(win_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (rd_i) rd_q <= {1'b0, pend, ie_q, mask_q};
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/rst_mask_ctrl_chk.sv
module rst_mask_ctrl_chk
  import rst_mask_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [WR_CLR_BIT:0] wr_lo,
  input logic              ack_i,
  input logic              ie_q,
  input lvl_vec_t          mask_q,
  input lvl_vec_t          pend,
  input logic              irq_o,
  input logic [LVL_W-1:0]  irq_level_o
);
  assert_mask_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i || !wr_lo[WR_MSE_BIT]) |=> $stable(mask_q));

  assert_mask_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_lo[WR_MSE_BIT]) |=> (mask_q == $past(wr_lo[NUM_LVL-1:0])));

  assert_wr_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_lo[WR_CLR_BIT] && !pend[EDGE_LVL]) |=> !pend[EDGE_LVL]);

  assert_no_masked_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mask_q[irq_level_o]);

  assert_prio_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_level_o != LVL_W'(EDGE_LVL)) |-> !(pend[EDGE_LVL] && !mask_q[EDGE_LVL]));

  assert_ie_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie_q);

  assert_ack_ie_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ie_q);
endmodule

bind rst_mask_ctrl rst_mask_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .wr_lo      (wr_data_i[rst_mask_pkg::WR_CLR_BIT:0]),
  .ack_i      (ack_i),
  .ie_q       (ie_q),
  .mask_q     (mask_q),
  .pend       (pend),
  .irq_o      (irq_o),
  .irq_level_o(irq_level_o)
);

// File: tb/rst_mask_ctrl_tb_top.sv
module rst_mask_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] irq_pin_i = '0;
  logic       wr_i = 0, rd_i = 0, ie_set_i = 0, ie_clr_i = 0, ack_i = 0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o, vector_o;
  logic       irq_o;
  logic [1:0] irq_level_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rst_mask_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_pin_i(irq_pin_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
    .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .ack_i(ack_i),
    .irq_o(irq_o), .irq_level_o(irq_level_o), .vector_o(vector_o)
  );

  typedef struct {
    string      tag;
    logic       chk_rd;
    logic [7:0] rd;
    logic       irq;
    logic [1:0] lvl;
    logic [7:0] vec;
  } exp_t;

  exp_t q[$];
  event sample_ev;
  int   n_vec = 0, n_bad = 0;
  bit   done = 0;

  // reference model state
  logic [2:0] m_mask = 3'b111;
  logic       m_latch = 0, m_ie = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic void model_req(output logic irq, output logic [1:0] lvl,
                                    output logic [7:0] vec);
    logic [2:0] p;
    p = {m_latch, irq_pin_i[1], irq_pin_i[0]} & ~m_mask;
    irq = m_ie && (p != 0);
    lvl = !irq ? 2'd0 : p[2] ? 2'd2 : p[1] ? 2'd1 : 2'd0;
    vec = !irq ? 8'h00 : (lvl == 2) ? 8'h3C : (lvl == 1) ? 8'h34 : 8'h2C;
  endfunction

  task automatic expect_now(input string tag, input logic chk_rd);
    exp_t e;
    e.tag = tag;
    e.chk_rd = chk_rd;
    e.rd = {1'b0, m_latch, irq_pin_i[1], irq_pin_i[0], m_ie, m_mask};
    model_req(e.irq, e.lvl, e.vec);
    q.push_back(e);
    -> sample_ev;
    #1;
  endtask

  task automatic set_pins(input logic [2:0] p);
    if (p[2] && !irq_pin_i[2]) m_latch = 1;
    irq_pin_i = p;
    tick(5);
  endtask

  task automatic write_byte(input logic [7:0] b);
    wr_i = 1; wr_data_i = b;
    tick(1);
    wr_i = 0; wr_data_i = '0;
    if (b[4]) m_latch = 0;
    if (b[3]) m_mask = b[2:0];
  endtask

  task automatic read_status(input string tag);
    rd_i = 1; tick(1); rd_i = 0;
    expect_now(tag, 1'b1);
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(1); s = 0;
  endtask

  task automatic do_ack();
    logic irq; logic [1:0] lvl; logic [7:0] vec;
    model_req(irq, lvl, vec);
    pulse(ack_i);
    if (irq && lvl == 2) m_latch = 0;
    m_ie = 0;
  endtask

  // monitor
  initial forever begin
    @(sample_ev);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (irq_o !== e.irq || irq_level_o !== e.lvl || vector_o !== e.vec) begin
        n_bad++;
        $display("FAIL %s: irq/lvl/vec got %0b/%0d/%h exp %0b/%0d/%h",
                 e.tag, irq_o, irq_level_o, vector_o, e.irq, e.lvl, e.vec);
      end
      if (e.chk_rd && rd_data_o !== e.rd) begin
        n_bad++;
        $display("FAIL %s: status got %h exp %h", e.tag, rd_data_o, e.rd);
      end
    end
  end

  initial begin
    tick(3);
    rst_ni = 1;
    tick(2);
    read_status("R1 reset state R10");

    // short 7.5 pulse stays pending
    irq_pin_i = 3'b100; m_latch = 1; tick(2);
    irq_pin_i = 3'b000; tick(5);
    read_status("R4 latch after pulse");

    write_byte(8'h0E);
    read_status("R2 masks loaded, R8 no irq while ie=0");

    pulse(ie_set_i); m_ie = 1;
    expect_now("R6 masked 7.5 gives no request R12", 1'b0);

    write_byte(8'h08);
    read_status("R7 7.5 wins vector 3C");

    set_pins(3'b011);
    read_status("R7 7.5 over 6.5 and 5.5, R5 levels shown");

    write_byte(8'h10);
    read_status("R3 clear without mse, R2 masks kept, R7 6.5 wins");

    write_byte(8'hEA);
    read_status("R11 high bits ignored, R5 masked 6.5 still shown, R7 5.5 wins");

    do_ack();
    read_status("R9 ack clears ie");

    pulse(ie_set_i); m_ie = 1;
    set_pins(3'b111);
    set_pins(3'b011);
    write_byte(8'h08);
    read_status("R7 7.5 wins again");

    do_ack();
    read_status("R9 ack of 7.5 clears latch");

    pulse(ie_set_i); m_ie = 1;
    expect_now("R9 6.5 wins after 7.5 acked", 1'b0);

    pulse(ie_clr_i); m_ie = 0;
    expect_now("R12 ie cleared", 1'b0);

    write_byte(8'h07);
    pulse(ie_set_i); m_ie = 1;
    read_status("R2 write without mse keeps masks");

    set_pins(3'b001);
    read_status("R5 6.5 falls, 5.5 wins");

    set_pins(3'b000);
    read_status("R8 nothing pending");

    tick(2);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule